// File: doc/BRIEF.md
# Blinking Warning Sign Controller

A small Moore state machine that sequences a five-lamp directional warning sign. The lamps are wired in three groups: a front pair, a middle pair and a single tip lamp. While the enable switch is on, the sign lights progressively more of the arrow on each step: dark, then the front pair, then front and middle pairs, then all five lamps, and then back to dark.

The phase is held in a two-bit register, and every lamp output is decoded from that register alone. Turning the switch off sends the machine to the dark phase at the next clock edge. An optional step-enable input lets an external divider set a visible blink rate. The block itself does no clock division and does not drive the lamps electrically.

Top module: `blink_sign_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts the machine in phase 0 (binary 00), with all three lamp outputs low.
- R2: Each lamp output depends only on the phase. `lamp_front` is high in phases 1, 2 and 3. `lamp_mid` is high in phases 2 and 3. `lamp_tip` is high only in phase 3. All three are low in phase 0.
- R3: When `sw_on`=1 and `step_en`=1 at a rising edge, the phase moves up by one. The phases, in order, are 0 (dark), 1 (front), 2 (front+mid) and 3 (all).
- R4: From phase 3, with `sw_on`=1 and `step_en`=1, the next phase is 0.
- R5: When `sw_on`=0 at a rising edge, the next phase is 0. This holds for any current phase and any value of `step_en`.
- R6: When `sw_on`=1 and `step_en`=0 at a rising edge, the phase is unchanged. This applies when parameter `USE_STEP_EN`=1, which is the default. When it is 0, `step_en` is ignored and the phase advances on every edge.
- R7: A change of `sw_on` or `step_en` between clock edges leaves all lamp outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sw_on | input | 1 | Enable switch; 0 forces the dark phase |
| step_en | input | 1 | Step permission from an external rate divider |
| lamp_front | output | 1 | Drives lamps 1 and 2 |
| lamp_mid | output | 1 | Drives lamps 3 and 4 |
| lamp_tip | output | 1 | Drives lamp 5 |

## Verification
The hardest case to reach is the switch dropping while the arrow is partly or fully lit, together with a held step-enable. The force to dark has to override both advancing and holding. To get there, the stimulus first steps the machine to each intermediate phase, with pauses created by holding step_enable low. It then lowers the switch, with step_enable both high and low, and checks that the sign is dark after exactly one edge. The Moore property is tested by toggling the inputs just after a sample point and reading the lamps again before the next edge.

// File: rtl/blink_pkg.sv
package blink_pkg;
   localparam int PHASES = 4;
   localparam int PH_W   = $clog2(PHASES);
   localparam int GROUPS = PHASES - 1;
   typedef logic [PH_W-1:0] phase_t;
   localparam phase_t PH_DARK = '0;
endpackage

// File: rtl/blink_state_reg.sv
module blink_state_reg
   import blink_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  phase_t nxt,
   output phase_t cur
);
   always_ff @(posedge clk) begin
      if (rst) cur <= PH_DARK;
      else     cur <= nxt;
   end
endmodule

// File: rtl/blink_next_phase.sv
module blink_next_phase
   import blink_pkg::*;
#(
   parameter bit USE_STEP_EN = 1'b1
)(
   input  phase_t cur,
   input  logic   sw_on,
   input  logic   step_en,
   output phase_t nxt
);
   localparam phase_t LAST = phase_t'(PHASES - 1);
   logic adv;

   generate
      if (USE_STEP_EN) begin : g_gated
         assign adv = step_en;
      end else begin : g_free
         logic unused_step;
         assign unused_step = step_en;
         assign adv = 1'b1;
      end
   endgenerate

   always_comb begin
      if (!sw_on)        nxt = PH_DARK;
      else if (!adv)     nxt = cur;
      else if (cur == LAST) nxt = PH_DARK;
      else               nxt = cur + phase_t'(1);
   end
endmodule

// File: rtl/blink_lamp_decode.sv
module blink_lamp_decode
   import blink_pkg::*;
(
   input  phase_t            cur,
   output logic [GROUPS-1:0] grp
);
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp[g] = (cur > phase_t'(g));
   end
endmodule

// File: rtl/blink_sign_ctrl.sv
module blink_sign_ctrl
   import blink_pkg::*;
#(
   parameter bit USE_STEP_EN = 1'b1
)(
   input  logic clk,
   input  logic rst,
   input  logic sw_on,
   input  logic step_en,
   output logic lamp_front,
   output logic lamp_mid,
   output logic lamp_tip
);
   initial begin
      if (PHASES != 4) $error("blink_sign_ctrl: four phases required");
      if (GROUPS != 3) $error("blink_sign_ctrl: three lamp groups required");
   end

   phase_t            cur, nxt;
   logic [GROUPS-1:0] grp;

   blink_next_phase #(.USE_STEP_EN(USE_STEP_EN)) u_next (
      .cur(cur), .sw_on(sw_on), .step_en(step_en), .nxt(nxt));

   blink_state_reg u_reg (.clk(clk), .rst(rst), .nxt(nxt), .cur(cur));

   blink_lamp_decode u_dec (.cur(cur), .grp(grp));

   assign lamp_front = grp[0];
   assign lamp_mid   = grp[1];
   assign lamp_tip   = grp[2];
endmodule

// File: rtl/blink_sign_ctrl_chk.sv
module blink_sign_ctrl_chk #(
   parameter bit USE_STEP_EN = 1'b1
)(
   input logic clk,
   input logic rst,
   input logic sw_on,
   input logic step_en,
   input logic lamp_front,
   input logic lamp_mid,
   input logic lamp_tip
);
   logic go;
   assign go = sw_on && (step_en || !USE_STEP_EN);

   a_r1_reset_dark: assert property (@(posedge clk)
      rst |=> (!lamp_front && !lamp_mid && !lamp_tip));

   a_r2_nested_groups: assert property (@(posedge clk) disable iff (rst)
      (lamp_tip |-> lamp_mid) and (lamp_mid |-> lamp_front));

   a_r3_dark_to_front: assert property (@(posedge clk) disable iff (rst)
      (go && !lamp_front) |=> (lamp_front && !lamp_mid));

   a_r3_front_to_mid: assert property (@(posedge clk) disable iff (rst)
      (go && lamp_front && !lamp_mid) |=> (lamp_mid && !lamp_tip));

   a_r4_wrap_dark: assert property (@(posedge clk) disable iff (rst)
      (go && lamp_tip) |=> !lamp_front);

   a_r5_switch_off_dark: assert property (@(posedge clk) disable iff (rst)
      !sw_on |=> (!lamp_front && !lamp_mid && !lamp_tip));

   a_r6_hold_phase: assert property (@(posedge clk) disable iff (rst)
      (sw_on && !go) |=> ($stable(lamp_front) && $stable(lamp_mid) && $stable(lamp_tip)));
endmodule

bind blink_sign_ctrl blink_sign_ctrl_chk #(.USE_STEP_EN(USE_STEP_EN)) u_chk (
   .clk(clk), .rst(rst), .sw_on(sw_on), .step_en(step_en),
   .lamp_front(lamp_front), .lamp_mid(lamp_mid), .lamp_tip(lamp_tip));

// File: tb/blink_sign_ctrl_bench.sv
`timescale 1ns/1ps
module blink_sign_ctrl_bench;
   logic clk = 1'b0, rst = 1'b1, sw_on = 1'b0, step_en = 1'b0;
   logic lamp_front, lamp_mid, lamp_tip;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   blink_sign_ctrl u_blink_sign_ctrl (
      .clk(clk), .rst(rst), .sw_on(sw_on), .step_en(step_en),
      .lamp_front(lamp_front), .lamp_mid(lamp_mid), .lamp_tip(lamp_tip));

   function automatic logic [2:0] lamps_of(int ph);
      case (ph)
         1: return 3'b100;
         2: return 3'b110;
         3: return 3'b111;
         default: return 3'b000;
      endcase
   endfunction

   task automatic chk(string req, int ph);
      logic [2:0] act, exp;
      act = {lamp_front, lamp_mid, lamp_tip};
      exp = lamps_of(ph);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: lamps act=%b exp=%b (phase %0d)", req, act, exp, ph);
      end
   endtask

   // one rising edge, then sample at the following falling edge
   task automatic step(logic s, logic t);
      sw_on = s; step_en = t;
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst = 1'b1; step(1'b1, 1'b1); step(1'b1, 1'b1);
      chk("R1 reset dark", 0);
      rst = 1'b0;
   endtask

   task automatic t_full_cycle;
      for (int k = 1; k <= 8; k++) begin
         step(1'b1, 1'b1);
         chk((k % 4 == 0) ? "R4 wrap to dark" : "R3 R2 advance", k % 4);
      end
   endtask

   task automatic t_hold;
      step(1'b1, 1'b1);
      chk("R3 to front", 1);
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 1'b0);
         chk("R6 hold without step", 1);
      end
      step(1'b1, 1'b1);
      chk("R3 resume", 2);
   endtask

   task automatic t_drop(int target, logic t_at_drop);
      step(1'b0, 1'b0);
      chk("R5 pre-clear", 0);
      for (int k = 0; k < target; k++) begin
         step(1'b1, 1'b1);
         step(1'b1, 1'b0);
      end
      chk("R2 reached phase", target);
      step(1'b0, t_at_drop);
      chk("R5 switch off forces dark", 0);
      step(1'b0, 1'b1);
      chk("R5 stays dark", 0);
   endtask

   task automatic t_moore;
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      chk("R2 phase 2", 2);
      #0.5 sw_on = 1'b0; step_en = 1'b0;
      #0.5 chk("R7 no change before edge", 2);
      #0.3 sw_on = 1'b1; step_en = 1'b1;
      #0.3 chk("R7 no change before edge", 2);
      step(1'b1, 1'b1);
      chk("R3 phase 3", 3);
   endtask

   initial begin
      @(negedge clk);
      t_reset;
      t_full_cycle;
      t_hold;
      t_drop(1, 1'b1);
      t_drop(2, 1'b0);
      t_drop(3, 1'b1);
      t_drop(3, 1'b0);
      t_moore;
      t_reset;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule